// File: doc/BRIEF.md
# Two-Stage Translation Entry Combiner

This block takes a pair of translation entries that describe one access, the first mapping a virtual page to an intermediate page and the second mapping that intermediate page to a physical page. It folds them into a single entry that can be written straight into a first-stage translation cache. The first stage's virtual page number and the second stage's physical frame number end up in that one entry.

When the two stages use different page sizes, the combined entry always uses the smaller page. When the first stage is the larger page, the virtual page number is rebuilt from the original virtual address. When the second stage is the larger page, the frame number is rebuilt by taking the part of the intermediate address that lies inside the second-stage page. Cacheability, memory type, shareability and execute permission are merged by fixed precedence rules.

If the second stage reported a fault, no entry is produced. Instead, a fault record carrying the original virtual address is emitted. The block is fully pipelined, with one request per cycle and its result exactly one cycle later.

Top module: `s2c_top`

## Requirements
- R1: A request with `in_valid`=1 and `in_fault`=0 produces `done`=1 in the next cycle only. Every other cycle has `done`=0, and `done` is 0 after reset.
- R2: The merged execute-never bit `m_xn` is the OR of `s1_xn` and `s2_xn`.
- R3: The merged page size `m_n` is the smaller of `s1_n` and `s2_n`. When `s1_n` > `s2_n`, `m_vpn` is `in_va >> s2_n` and `m_pfn` is `s2_pfn`.
- R4: When `s1_n` < `s2_n`, `m_vpn` is `s1_vpn` and `m_pfn` = (((`s2_pfn` << `s2_n`) | ((`s1_pfn` << `s1_n`) & (2^`s2_n` - 1))) >> `s1_n`). Both shifts are truncated to ADDR_W bits.
- R5: When `s1_n` = `s2_n`, `m_pfn` is `s2_pfn` and `m_vpn` is `s1_vpn`, both unchanged.
- R6: Inner cacheability code: `m_inner` is 0 (non-cacheable) if either stage's code is 0. Otherwise it is 2 (write-through) if either stage's code is 2. Otherwise it is 3 (write-back).
- R7: The outer code `m_outer` follows the R6 rule, applied to `s1_outer` and `s2_outer` alone and independently of the inner codes.
- R8: Memory type encoding is 0 normal, 1 device, 2 strongly-ordered, with 3 read as 2. `m_mtype` is the more restrictive type of the two stages.
- R9: If `m_mtype` is not 0, or if `m_inner` and `m_outer` are both 0, then `m_shr` and `m_oshr` are 1. Otherwise `m_shr` = `s1_shr`|`s2_shr` and `m_oshr` = `s1_oshr`|`s2_oshr`.
- R10: `m_nc` is 1 when `m_mtype` is not 0, or when `m_inner` is 0, or when `m_outer` is 0.
- R11: A request with `in_fault`=1 gives `flt_valid`=1 in the next cycle, with `flt_va` equal to that request's `in_va`. That cycle has `done`=0, and the merged entry outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_fault | input | 1 | Second stage reported a fault |
| in_va | input | ADDR_W | Original virtual address |
| s1_pfn | input | ADDR_W | Stage-1 frame number (intermediate) |
| s1_vpn | input | ADDR_W | Stage-1 virtual page number |
| s1_n | input | SIZE_W | Stage-1 log2 page size |
| s1_xn | input | 1 | Stage-1 execute-never |
| s1_inner | input | 2 | Stage-1 inner cacheability code |
| s1_outer | input | 2 | Stage-1 outer cacheability code |
| s1_mtype | input | 2 | Stage-1 memory type |
| s1_shr | input | 1 | Stage-1 shareable |
| s1_oshr | input | 1 | Stage-1 outer shareable |
| s2_pfn | input | ADDR_W | Stage-2 frame number (physical) |
| s2_n | input | SIZE_W | Stage-2 log2 page size |
| s2_xn | input | 1 | Stage-2 execute-never |
| s2_inner | input | 2 | Stage-2 inner cacheability code |
| s2_outer | input | 2 | Stage-2 outer cacheability code |
| s2_mtype | input | 2 | Stage-2 memory type |
| s2_shr | input | 1 | Stage-2 shareable |
| s2_oshr | input | 1 | Stage-2 outer shareable |
| done | output | 1 | Merged entry valid (one-cycle pulse) |
| m_pfn | output | ADDR_W | Merged frame number |
| m_vpn | output | ADDR_W | Merged virtual page number |
| m_n | output | SIZE_W | Merged log2 page size |
| m_xn | output | 1 | Merged execute-never |
| m_inner | output | 2 | Merged inner code |
| m_outer | output | 2 | Merged outer code |
| m_mtype | output | 2 | Merged memory type |
| m_shr | output | 1 | Merged shareable |
| m_oshr | output | 1 | Merged outer shareable |
| m_nc | output | 1 | Merged non-cacheable flag |
| flt_valid | output | 1 | Fault record valid (one-cycle pulse) |
| flt_va | output | ADDR_W | Virtual address of the faulting request |

## Verification
The block keeps no state beyond one result register. A wrong merge therefore shows up on the outputs in the single cycle after the request that caused it, and it cannot spread to later requests. A misdirected fault path shows up as a `done` pulse in place of `flt_valid`, or as a merged entry that changes when it should hold. A reference model steps alongside the design, so any wrong field is caught in the same cycle it appears. The size cases are driven at the equal, larger and smaller boundaries, and all sixteen cacheability pairs are driven for each attribute level.

// File: rtl/s2c_pkg.sv
package s2c_pkg;
    parameter int ADDR_W = 40;
    parameter int SIZE_W = 6;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'd0,
        MT_DEVICE = 2'd1,
        MT_STRONG = 2'd2
    } mtype_e;

    localparam logic [1:0] CC_NC = 2'd0;
    localparam logic [1:0] CC_WT = 2'd2;
    localparam logic [1:0] CC_WB = 2'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] pfn;
        logic [ADDR_W-1:0] vpn;
        logic [SIZE_W-1:0] n;
        logic              xn;
        logic [1:0]        inner;
        logic [1:0]        outer;
        mtype_e            mtype;
        logic              shr;
        logic              oshr;
        logic              nc;
    } entry_t;

    function automatic mtype_e norm_mtype(input logic [1:0] code);
        return (code >= 2'd2) ? MT_STRONG : mtype_e'(code);
    endfunction

    function automatic mtype_e strictest(input mtype_e a, input mtype_e b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/s2c_size_merge.sv
module s2c_size_merge
    import s2c_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SIZE_W
) (
    input  logic [AW-1:0] va,
    input  logic [AW-1:0] s1_pfn,
    input  logic [AW-1:0] s1_vpn,
    input  logic [SW-1:0] s1_n,
    input  logic [AW-1:0] s2_pfn,
    input  logic [SW-1:0] s2_n,
    output logic [AW-1:0] pfn,
    output logic [AW-1:0] vpn,
    output logic [SW-1:0] n
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] ipa;
    logic [AW-1:0] s2_base;
    logic [AW-1:0] low_mask;
    logic [AW-1:0] rebuilt;

    always_comb begin
        ipa      = s1_pfn << s1_n;
        s2_base  = s2_pfn << s2_n;
        low_mask = (ONE << s2_n) - ONE;
        rebuilt  = (s2_base | (ipa & low_mask)) >> s1_n;
        if (s1_n > s2_n) begin
            n   = s2_n;
            vpn = va >> s2_n;
            pfn = s2_pfn;
        end else if (s1_n < s2_n) begin
            n   = s1_n;
            vpn = s1_vpn;
            pfn = rebuilt;
        end else begin
            n   = s1_n;
            vpn = s1_vpn;
            pfn = s2_pfn;
        end
    end
endmodule

// File: rtl/s2c_cache_fold.sv
module s2c_cache_fold
    import s2c_pkg::*;
(
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [1:0] y
);
    always_comb begin
        if (a == CC_NC || b == CC_NC)      y = CC_NC;
        else if (a == CC_WT || b == CC_WT) y = CC_WT;
        else                               y = CC_WB;
    end
endmodule

// File: rtl/s2c_attr_merge.sv
module s2c_attr_merge
    import s2c_pkg::*;
(
    input  logic [1:0] s1_inner,
    input  logic [1:0] s1_outer,
    input  logic [1:0] s1_mtype,
    input  logic       s1_shr,
    input  logic       s1_oshr,
    input  logic [1:0] s2_inner,
    input  logic [1:0] s2_outer,
    input  logic [1:0] s2_mtype,
    input  logic       s2_shr,
    input  logic       s2_oshr,
    output logic [1:0] inner,
    output logic [1:0] outer,
    output mtype_e     mtype,
    output logic       shr,
    output logic       oshr,
    output logic       nc
);
    localparam int LEVELS = 2;

    logic [LEVELS-1:0][1:0] a_codes;
    logic [LEVELS-1:0][1:0] b_codes;
    logic [LEVELS-1:0][1:0] y_codes;

    assign a_codes = {s1_outer, s1_inner};
    assign b_codes = {s2_outer, s2_inner};

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        s2c_cache_fold u_fold (
            .a (a_codes[g]),
            .b (b_codes[g]),
            .y (y_codes[g])
        );
    end

    assign inner = y_codes[0];
    assign outer = y_codes[1];

    always_comb begin
        mtype = strictest(norm_mtype(s1_mtype), norm_mtype(s2_mtype));
        if (mtype != MT_NORMAL || (inner == CC_NC && outer == CC_NC)) begin
            shr  = 1'b1;
            oshr = 1'b1;
        end else begin
            shr  = s1_shr | s2_shr;
            oshr = s1_oshr | s2_oshr;
        end
        nc = (mtype != MT_NORMAL) || (inner == CC_NC) || (outer == CC_NC);
    end
endmodule

// File: rtl/s2c_top.sv
module s2c_top
    import s2c_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SIZE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_fault,
    input  logic [AW-1:0] in_va,
    input  logic [AW-1:0] s1_pfn,
    input  logic [AW-1:0] s1_vpn,
    input  logic [SW-1:0] s1_n,
    input  logic          s1_xn,
    input  logic [1:0]    s1_inner,
    input  logic [1:0]    s1_outer,
    input  logic [1:0]    s1_mtype,
    input  logic          s1_shr,
    input  logic          s1_oshr,
    input  logic [AW-1:0] s2_pfn,
    input  logic [SW-1:0] s2_n,
    input  logic          s2_xn,
    input  logic [1:0]    s2_inner,
    input  logic [1:0]    s2_outer,
    input  logic [1:0]    s2_mtype,
    input  logic          s2_shr,
    input  logic          s2_oshr,
    output logic          done,
    output logic [AW-1:0] m_pfn,
    output logic [AW-1:0] m_vpn,
    output logic [SW-1:0] m_n,
    output logic          m_xn,
    output logic [1:0]    m_inner,
    output logic [1:0]    m_outer,
    output logic [1:0]    m_mtype,
    output logic          m_shr,
    output logic          m_oshr,
    output logic          m_nc,
    output logic          flt_valid,
    output logic [AW-1:0] flt_va
);
    entry_t        nxt;
    entry_t        ent_q;
    logic          done_q;
    logic          flt_q;
    logic [AW-1:0] flt_va_q;
    logic          accept;

    s2c_size_merge #(.AW(AW), .SW(SW)) u_size (
        .va     (in_va),
        .s1_pfn (s1_pfn),
        .s1_vpn (s1_vpn),
        .s1_n   (s1_n),
        .s2_pfn (s2_pfn),
        .s2_n   (s2_n),
        .pfn    (nxt.pfn),
        .vpn    (nxt.vpn),
        .n      (nxt.n)
    );

    s2c_attr_merge u_attr (
        .s1_inner (s1_inner),
        .s1_outer (s1_outer),
        .s1_mtype (s1_mtype),
        .s1_shr   (s1_shr),
        .s1_oshr  (s1_oshr),
        .s2_inner (s2_inner),
        .s2_outer (s2_outer),
        .s2_mtype (s2_mtype),
        .s2_shr   (s2_shr),
        .s2_oshr  (s2_oshr),
        .inner    (nxt.inner),
        .outer    (nxt.outer),
        .mtype    (nxt.mtype),
        .shr      (nxt.shr),
        .oshr     (nxt.oshr),
        .nc       (nxt.nc)
    );

    assign nxt.xn = s1_xn | s2_xn;
    assign accept = in_valid && !in_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q    <= '0;
            done_q   <= 1'b0;
            flt_q    <= 1'b0;
            flt_va_q <= '0;
        end else begin
            done_q <= accept;
            flt_q  <= in_valid && in_fault;
            if (accept) ent_q <= nxt;
            if (in_valid && in_fault) flt_va_q <= in_va;
        end
    end

    assign done      = done_q;
    assign m_pfn     = ent_q.pfn;
    assign m_vpn     = ent_q.vpn;
    assign m_n       = ent_q.n;
    assign m_xn      = ent_q.xn;
    assign m_inner   = ent_q.inner;
    assign m_outer   = ent_q.outer;
    assign m_mtype   = ent_q.mtype;
    assign m_shr     = ent_q.shr;
    assign m_oshr    = ent_q.oshr;
    assign m_nc      = ent_q.nc;
    assign flt_valid = flt_q;
    assign flt_va    = flt_va_q;
endmodule

// File: rtl/s2c_checker.sv
module s2c_checker #(
    parameter int AW = 40,
    parameter int SW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_fault,
    input logic [AW-1:0] in_va,
    input logic [SW-1:0] s1_n,
    input logic [SW-1:0] s2_n,
    input logic          s1_xn,
    input logic          s2_xn,
    input logic          done,
    input logic [SW-1:0] m_n,
    input logic          m_xn,
    input logic [1:0]    m_inner,
    input logic [1:0]    m_outer,
    input logic [1:0]    m_mtype,
    input logic          m_shr,
    input logic          m_oshr,
    input logic          m_nc,
    input logic          flt_valid,
    input logic [AW-1:0] flt_va,
    input logic [AW-1:0] m_pfn
);
    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_fault) |=> done);
    // R1
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && !in_fault) |=> !done);
    // R2
    xn_or_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_fault) |=> (m_xn == ($past(s1_xn) | $past(s2_xn))));
    // R3
    size_min_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_fault) |=> (m_n <= $past(s1_n) && m_n <= $past(s2_n)));
    // R6
    inner_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (m_inner != 2'd1));
    // R7
    outer_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (m_outer != 2'd1));
    // R8
    mtype_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (m_mtype != 2'd3));
    // R9
    share_force_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (m_mtype != 2'd0 || (m_inner == 2'd0 && m_outer == 2'd0))) |-> (m_shr && m_oshr));
    // R10
    nc_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && m_mtype != 2'd0) |-> m_nc);
    // R11
    fault_record_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fault) |=> (flt_valid && !done && flt_va == $past(in_va)));
    // R11
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fault) |=> $stable(m_pfn));
endmodule

bind s2c_top s2c_checker #(.AW(AW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_fault  (in_fault),
    .in_va     (in_va),
    .s1_n      (s1_n),
    .s2_n      (s2_n),
    .s1_xn     (s1_xn),
    .s2_xn     (s2_xn),
    .done      (done),
    .m_n       (m_n),
    .m_xn      (m_xn),
    .m_inner   (m_inner),
    .m_outer   (m_outer),
    .m_mtype   (m_mtype),
    .m_shr     (m_shr),
    .m_oshr    (m_oshr),
    .m_nc      (m_nc),
    .flt_valid (flt_valid),
    .flt_va    (flt_va),
    .m_pfn     (m_pfn)
);

// File: tb/s2c_top_test.sv
`timescale 1ns/1ps
module s2c_top_test;
    localparam int AW = 40;
    localparam int SW = 6;
    localparam logic [63:0] AMASK = (64'd1 << AW) - 64'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          in_valid = 0, in_fault = 0;
    logic [AW-1:0] in_va = 0, s1_pfn = 0, s1_vpn = 0, s2_pfn = 0;
    logic [SW-1:0] s1_n = 0, s2_n = 0;
    logic          s1_xn = 0, s2_xn = 0, s1_shr = 0, s1_oshr = 0, s2_shr = 0, s2_oshr = 0;
    logic [1:0]    s1_inner = 0, s1_outer = 0, s1_mtype = 0, s2_inner = 0, s2_outer = 0, s2_mtype = 0;

    logic          done, m_xn, m_shr, m_oshr, m_nc, flt_valid;
    logic [AW-1:0] m_pfn, m_vpn, flt_va;
    logic [SW-1:0] m_n;
    logic [1:0]    m_inner, m_outer, m_mtype;

    s2c_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fault(in_fault), .in_va(in_va),
        .s1_pfn(s1_pfn), .s1_vpn(s1_vpn), .s1_n(s1_n), .s1_xn(s1_xn),
        .s1_inner(s1_inner), .s1_outer(s1_outer), .s1_mtype(s1_mtype),
        .s1_shr(s1_shr), .s1_oshr(s1_oshr),
        .s2_pfn(s2_pfn), .s2_n(s2_n), .s2_xn(s2_xn),
        .s2_inner(s2_inner), .s2_outer(s2_outer), .s2_mtype(s2_mtype),
        .s2_shr(s2_shr), .s2_oshr(s2_oshr),
        .done(done), .m_pfn(m_pfn), .m_vpn(m_vpn), .m_n(m_n), .m_xn(m_xn),
        .m_inner(m_inner), .m_outer(m_outer), .m_mtype(m_mtype),
        .m_shr(m_shr), .m_oshr(m_oshr), .m_nc(m_nc),
        .flt_valid(flt_valid), .flt_va(flt_va)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // expected state of the model, updated once per request
    logic        e_done, e_flt;
    logic [63:0] e_pfn, e_vpn, e_n, e_xn, e_inner, e_outer, e_mt, e_shr, e_oshr, e_nc, e_fva;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] fold(input logic [1:0] a, input logic [1:0] b);
        if (a == 0 || b == 0) return 2'd0;
        if (a == 2 || b == 2) return 2'd2;
        return 2'd3;
    endfunction

    task automatic model();
        logic [63:0] ipa, base, lm;
        int mt1, mt2;
        e_done = in_valid && !in_fault;
        e_flt  = in_valid && in_fault;
        if (e_flt) e_fva = {24'd0, in_va};
        if (e_done) begin
            ipa  = ({24'd0, s1_pfn} << s1_n) & AMASK;
            base = ({24'd0, s2_pfn} << s2_n) & AMASK;
            lm   = ((64'd1 << s2_n) - 64'd1) & AMASK;
            if (s1_n > s2_n) begin
                e_n = s2_n; e_vpn = {24'd0, in_va} >> s2_n; e_pfn = {24'd0, s2_pfn};
            end else if (s1_n < s2_n) begin
                e_n = s1_n; e_vpn = {24'd0, s1_vpn}; e_pfn = (base | (ipa & lm)) >> s1_n;
            end else begin
                e_n = s1_n; e_vpn = {24'd0, s1_vpn}; e_pfn = {24'd0, s2_pfn};
            end
            e_xn    = {63'd0, s1_xn | s2_xn};
            e_inner = {62'd0, fold(s1_inner, s2_inner)};
            e_outer = {62'd0, fold(s1_outer, s2_outer)};
            mt1 = (s1_mtype >= 2) ? 2 : int'(s1_mtype);
            mt2 = (s2_mtype >= 2) ? 2 : int'(s2_mtype);
            e_mt = (mt1 > mt2) ? 64'(mt1) : 64'(mt2);
            if (e_mt != 0 || (e_inner == 0 && e_outer == 0)) begin
                e_shr = 1; e_oshr = 1;
            end else begin
                e_shr = {63'd0, s1_shr | s2_shr}; e_oshr = {63'd0, s1_oshr | s2_oshr};
            end
            e_nc = (e_mt != 0 || e_inner == 0 || e_outer == 0) ? 64'd1 : 64'd0;
        end
    endtask

    task automatic compare();
        chk("R1 done", {63'd0, done}, {63'd0, e_done});
        chk("R11 flt_valid", {63'd0, flt_valid}, {63'd0, e_flt});
        if (e_flt) chk("R11 flt_va", {24'd0, flt_va}, e_fva);
        chk("R3 R4 R5 R11 m_pfn", {24'd0, m_pfn}, e_pfn);
        chk("R3 R4 R5 m_vpn", {24'd0, m_vpn}, e_vpn);
        chk("R3 m_n", {58'd0, m_n}, e_n);
        chk("R2 m_xn", {63'd0, m_xn}, e_xn);
        chk("R6 m_inner", {62'd0, m_inner}, e_inner);
        chk("R7 m_outer", {62'd0, m_outer}, e_outer);
        chk("R8 m_mtype", {62'd0, m_mtype}, e_mt);
        chk("R9 m_shr", {63'd0, m_shr}, e_shr);
        chk("R9 m_oshr", {63'd0, m_oshr}, e_oshr);
        chk("R10 m_nc", {63'd0, m_nc}, e_nc);
    endtask

    // apply current inputs for one clock, then compare at mid-cycle
    task automatic step();
        model();
        @(posedge clk);
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic req(input logic flt, input logic [AW-1:0] va,
                       input logic [AW-1:0] p1, input logic [AW-1:0] v1, input int n1,
                       input logic [AW-1:0] p2, input int n2);
        in_valid = 1; in_fault = flt; in_va = va;
        s1_pfn = p1; s1_vpn = v1; s1_n = SW'(n1);
        s2_pfn = p2; s2_n = SW'(n2);
        step();
    endtask

    task automatic idle();
        in_valid = 0; in_fault = 0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        e_done = 0; e_flt = 0; e_fva = 0;
        e_pfn = 0; e_vpn = 0; e_n = 0; e_xn = 0; e_inner = 0; e_outer = 0;
        e_mt = 0; e_shr = 0; e_oshr = 0; e_nc = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // reset state, R1
        #1; compare();
        @(negedge clk);

        // R5 equal sizes
        s1_inner = 3; s2_inner = 3; s1_outer = 3; s2_outer = 3; s1_shr = 1;
        req(0, 40'h12_3456_7000, 40'h0AB, 40'h123456, 12, 40'h0CD, 12);
        // R3 first stage larger
        req(0, 40'h12_3456_7890, 40'h1, 40'h9, 21, 40'h55, 12);
        // R4 first stage smaller: 4K inside 2M
        req(0, 40'h00_0040_1000, 40'h00123, 40'h401, 12, 40'h7, 21);
        // R4 again with larger gap
        req(0, 40'h00_8000_5000, 40'hABCDE, 40'h80005, 12, 40'h3, 30);
        idle();

        // R6 R7 all cacheability pairs, inner and outer driven differently
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                s1_inner = 2'(a); s2_inner = 2'(b);
                s1_outer = 2'(3 - b); s2_outer = 2'(a ^ 1);
                s1_shr = 2'(a) == 1; s2_oshr = 2'(b) == 3;
                req(0, 40'h1000, 40'h1, 40'h1, 12, 40'h2, 12);
            end
        end

        // R8 R9 R10 memory types
        s1_inner = 3; s2_inner = 3; s1_outer = 2; s2_outer = 3; s1_shr = 0; s2_shr = 0;
        s1_oshr = 0; s2_oshr = 0;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                s1_mtype = 2'(a); s2_mtype = 2'(b);
                req(0, 40'h2000, 40'h3, 40'h2, 12, 40'h4, 12);
            end
        end
        s1_mtype = 0; s2_mtype = 0;

        // R2 xn combos
        for (int a = 0; a < 4; a++) begin
            s1_xn = a[0]; s2_xn = a[1];
            req(0, 40'h3000, 40'h5, 40'h3, 12, 40'h6, 12);
        end

        // R11 fault holds entry, back-to-back with good requests
        req(1, 40'hFE_DCBA_9876, 40'h77, 40'h88, 12, 40'h99, 12);
        req(0, 40'h00_0000_4000, 40'h10, 40'h4, 12, 40'h20, 16);
        req(1, 40'h01_0203_0405, 40'h1, 40'h1, 12, 40'h1, 12);
        idle();
        idle();

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            in_valid = ($urandom % 4) != 0;
            in_fault = ($urandom % 5) == 0;
            in_va    = {$urandom, $urandom} & AMASK[AW-1:0];
            s1_pfn   = AW'($urandom); s1_vpn = AW'($urandom); s2_pfn = AW'($urandom);
            s1_n     = SW'(12 + $urandom % 19); s2_n = SW'(12 + $urandom % 19);
            s1_xn    = 1'($urandom); s2_xn = 1'($urandom);
            s1_inner = 2'($urandom); s2_inner = 2'($urandom);
            s1_outer = 2'($urandom); s2_outer = 2'($urandom);
            s1_mtype = 2'($urandom); s2_mtype = 2'($urandom);
            s1_shr   = 1'($urandom); s2_shr = 1'($urandom);
            s1_oshr  = 1'($urandom); s2_oshr = 1'($urandom);
            step();
        end
        idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule